// File: doc/BRIEF.md
# Priority Channel Group Conversion Sequencer

This block decides which input channel a multi-channel filter converts next for its high-priority channel group. Software supplies a bitmask of selected channels, a scan/single choice, a synchronous-start choice and a choice to hand results to DMA. Each accepted start request then runs one conversion (single mode) or one conversion of every selected channel (scan mode). For each conversion the block raises a one-cycle start pulse with the channel index and holds a pending flag until the datapath reports that the request has finished.

Two units can be chained. The `launch_o` pulse of a master unit feeds the `master_start_i` input of a slave unit, so one software start also launches the slave's group when the slave's synchronous option is set. The mode, sync and DMA options are writable only while the unit is disabled. Disabling the unit drops any conversion in flight.

Top module: `prio_group_seq`

## Requirements
- R1: In single mode (scan=0), each accepted start converts exactly one channel: the lowest selected channel at or above the internal pointer. When that conversion's done is accepted, the pointer moves one past that channel. Channel index n corresponds to bit n of the mask.
- R2: In single mode the pointer wraps. After the highest selected channel, the next start converts the lowest selected channel.
- R3: In scan mode (scan=1), one accepted start converts every selected channel in ascending order, beginning with the lowest. `conv_start_o` pulses in the cycle after the accepted start, and again in the cycle after each accepted done while selected channels remain.
- R4: A mask write while scan=0 resets the pointer, so the next single-mode start converts the lowest selected channel of the new mask.
- R5: A start request (software or synchronous) is ignored while `pending_o` is 1. It causes no extra conversion.
- R6: `launch_o` is 1 in any cycle where the unit is enabled, `pending_o` is 0 and `sw_start_i` is 1. With sync=1, a `master_start_i` pulse launches a request exactly like a software start. With sync=0, `master_start_i` has no effect.
- R7: A configuration write (`cfg_we_i`) updates scan, sync and DMA enable only while `unit_en_i` is 0. While enabled the write is ignored, and `scan_o`, `sync_o` and `dma_en_o` keep their values.
- R8: While `unit_en_i` is 0, the next clock edge clears `pending_o`, `conv_start_o` and `dma_req_o`, and resets the single-mode pointer to channel 0.
- R9: With DMA enable set, each accepted done raises `dma_req_o` for one cycle in the following cycle. With DMA enable clear, `dma_req_o` stays 0.
- R10: With an all-zero mask, a start is accepted (`launch_o` pulses) but no conversion is issued, and `pending_o` stays 0.
- R11: `pending_o` rises in the cycle after an accepted start that has a selected channel. It falls in the cycle after the done of the last conversion of that request.
- R12: `conv_done_i` is ignored when `pending_o` is 0 and in the cycle `conv_start_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| unit_en_i | input | 1 | Unit enable; 0 aborts and clears status |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_scan_i | input | 1 | Scan mode value to write |
| cfg_sync_i | input | 1 | Synchronous-start value to write |
| cfg_dma_i | input | 1 | DMA enable value to write |
| mask_we_i | input | 1 | Channel mask write strobe |
| mask_i | input | NCH | Channel select mask, bit n = channel n |
| sw_start_i | input | 1 | Software start strobe |
| master_start_i | input | 1 | Start launched by a master unit |
| conv_done_i | input | 1 | Datapath reports current conversion finished |
| conv_start_o | output | 1 | One-cycle conversion start pulse |
| conv_chan_o | output | $clog2(NCH) | Channel to convert |
| pending_o | output | 1 | A request is in progress |
| dma_req_o | output | 1 | DMA read request for a finished conversion |
| launch_o | output | 1 | Accepted software start, for slave chaining |
| scan_o | output | 1 | Current scan mode setting |
| sync_o | output | 1 | Current synchronous-start setting |
| dma_en_o | output | 1 | Current DMA enable setting |

## Verification
The hardest case to reach is the interplay between the single-mode pointer and events that move it without a finished conversion. Examples are a mask rewrite after the pointer has passed the new mask's lowest channel, a disable in the middle of a conversion, and a stray done while idle. The stimulus first walks the pointer to a known position with completed conversions. It then stalls the datapath responder so a request stays pending, disables the unit or rewrites the mask, and compares the next converted channel with the one a pointer-free sequencer would give. A behavioural model runs beside the design and is compared every cycle throughout.

// File: rtl/prio_group_seq_pkg.sv
// Shared types for the priority channel group sequencer.
package prio_group_seq_pkg;

    // Software-visible option set, locked while the unit is enabled.
    typedef struct packed {
        logic scan;
        logic sync;
        logic dma;
    } seq_cfg_t;

endpackage

// File: rtl/prio_group_seq_cfg.sv
// Option and mask registers.
// Assumes: options change only while the unit is disabled; the mask is
// writable at any time and survives disable.
module prio_group_seq_cfg
    import prio_group_seq_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           unit_en_i,
    input  logic           cfg_we_i,
    input  seq_cfg_t       cfg_i,
    input  logic           mask_we_i,
    input  logic [NCH-1:0] mask_i,
    output seq_cfg_t       cfg_o,
    output logic [NCH-1:0] mask_o
);

    // Option register: write accepted only while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_o <= '0;
        end else if (cfg_we_i && !unit_en_i) begin
            cfg_o <= cfg_i;
        end
    end

    // Channel mask register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_o <= '0;
        end else if (mask_we_i) begin
            mask_o <= mask_i;
        end
    end

endmodule

// File: rtl/prio_group_seq_pick.sv
// Finds the lowest set mask bit at or above base_i. With WRAP=1 it falls
// back to the lowest set bit overall when none lies at or above base_i.
// Assumes NCH >= 2; base_i may equal NCH (nothing at or above).
module prio_group_seq_pick #(
    parameter int NCH  = 8,
    parameter bit WRAP = 1'b1,
    localparam int CW  = $clog2(NCH)
) (
    input  logic [NCH-1:0] mask_i,
    input  logic [CW:0]    base_i,
    output logic           valid_o,
    output logic [CW-1:0]  idx_o
);

    logic          ge_valid;
    logic [CW-1:0] ge_idx;

    // Lowest selected channel at or above the base.
    always_comb begin
        ge_valid = 1'b0;
        ge_idx   = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (mask_i[i] && ((CW+1)'(i) >= base_i)) begin
                ge_valid = 1'b1;
                ge_idx   = CW'(i);
            end
        end
    end

    generate
        if (WRAP) begin : g_wrap
            logic          low_valid;
            logic [CW-1:0] low_idx;

            // Lowest selected channel overall, used on wrap-around.
            always_comb begin
                low_valid = 1'b0;
                low_idx   = '0;
                for (int i = NCH - 1; i >= 0; i--) begin
                    if (mask_i[i]) begin
                        low_valid = 1'b1;
                        low_idx   = CW'(i);
                    end
                end
            end

            assign valid_o = ge_valid | low_valid;
            assign idx_o   = ge_valid ? ge_idx : low_idx;
        end else begin : g_nowrap
            assign valid_o = ge_valid;
            assign idx_o   = ge_idx;
        end
    endgenerate

endmodule

// File: rtl/prio_group_seq_ctrl.sv
// Request sequencing: accepts starts, issues per-channel start pulses,
// tracks pending, advances the single-mode pointer, raises DMA requests.
// Assumes: conv_done_i is a one-cycle pulse per conversion; mask and
// options come from registers.
module prio_group_seq_ctrl
    import prio_group_seq_pkg::*;
#(
    parameter int NCH = 8,
    localparam int CW = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           unit_en_i,
    input  seq_cfg_t       cfg_i,
    input  logic [NCH-1:0] mask_i,
    input  logic           mask_we_i,
    input  logic           sw_start_i,
    input  logic           master_start_i,
    input  logic           conv_done_i,
    output logic           conv_start_o,
    output logic [CW-1:0]  conv_chan_o,
    output logic           pending_o,
    output logic           dma_req_o,
    output logic           launch_o
);

    logic          first_valid, next_valid;
    logic [CW-1:0] first_idx, next_idx, ptr_q, ptr_after;
    logic [CW:0]   first_base, next_base;
    logic          start_acc, done_acc;

    assign first_base = cfg_i.scan ? '0 : {1'b0, ptr_q};
    assign next_base  = {1'b0, conv_chan_o} + 1'b1;
    assign ptr_after  = (conv_chan_o == CW'(NCH - 1)) ? '0 : conv_chan_o + 1'b1;

    assign start_acc = !pending_o && (sw_start_i || (cfg_i.sync && master_start_i));
    assign done_acc  = pending_o && !conv_start_o && conv_done_i;
    assign launch_o  = unit_en_i && !pending_o && sw_start_i;

    prio_group_seq_pick #(.NCH(NCH), .WRAP(1'b1)) u_first (
        .mask_i  (mask_i),
        .base_i  (first_base),
        .valid_o (first_valid),
        .idx_o   (first_idx)
    );

    prio_group_seq_pick #(.NCH(NCH), .WRAP(1'b0)) u_next (
        .mask_i  (mask_i),
        .base_i  (next_base),
        .valid_o (next_valid),
        .idx_o   (next_idx)
    );

    // Sequencing state: pending, start pulse, channel, pointer, DMA pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || !unit_en_i) begin
            pending_o    <= 1'b0;
            conv_start_o <= 1'b0;
            conv_chan_o  <= '0;
            ptr_q        <= '0;
            dma_req_o    <= 1'b0;
        end else begin
            conv_start_o <= 1'b0;
            dma_req_o    <= 1'b0;
            if (start_acc) begin
                if (first_valid) begin
                    pending_o    <= 1'b1;
                    conv_start_o <= 1'b1;
                    conv_chan_o  <= first_idx;
                end
            end else if (done_acc) begin
                dma_req_o <= cfg_i.dma;
                if (cfg_i.scan && next_valid) begin
                    conv_chan_o  <= next_idx;
                    conv_start_o <= 1'b1;
                end else begin
                    pending_o <= 1'b0;
                    if (!cfg_i.scan) begin
                        ptr_q <= ptr_after;
                    end
                end
            end
            if (mask_we_i && !cfg_i.scan) begin
                ptr_q <= '0;
            end
        end
    end

endmodule

// File: rtl/prio_group_seq.sv
// Top of the priority channel group sequencer. Wires the option/mask
// registers to the sequencing controller and exposes the options.
// Assumes NCH >= 2 and a synchronous active-low reset.
module prio_group_seq
    import prio_group_seq_pkg::*;
#(
    parameter int NCH = 8,
    localparam int CW = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           unit_en_i,
    input  logic           cfg_we_i,
    input  logic           cfg_scan_i,
    input  logic           cfg_sync_i,
    input  logic           cfg_dma_i,
    input  logic           mask_we_i,
    input  logic [NCH-1:0] mask_i,
    input  logic           sw_start_i,
    input  logic           master_start_i,
    input  logic           conv_done_i,
    output logic           conv_start_o,
    output logic [CW-1:0]  conv_chan_o,
    output logic           pending_o,
    output logic           dma_req_o,
    output logic           launch_o,
    output logic           scan_o,
    output logic           sync_o,
    output logic           dma_en_o
);

    seq_cfg_t       cfg_wr, cfg_q;
    logic [NCH-1:0] mask_q;

    assign cfg_wr = '{scan: cfg_scan_i, sync: cfg_sync_i, dma: cfg_dma_i};

    prio_group_seq_cfg #(.NCH(NCH)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .unit_en_i (unit_en_i),
        .cfg_we_i  (cfg_we_i),
        .cfg_i     (cfg_wr),
        .mask_we_i (mask_we_i),
        .mask_i    (mask_i),
        .cfg_o     (cfg_q),
        .mask_o    (mask_q)
    );

    prio_group_seq_ctrl #(.NCH(NCH)) u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .unit_en_i      (unit_en_i),
        .cfg_i          (cfg_q),
        .mask_i         (mask_q),
        .mask_we_i      (mask_we_i),
        .sw_start_i     (sw_start_i),
        .master_start_i (master_start_i),
        .conv_done_i    (conv_done_i),
        .conv_start_o   (conv_start_o),
        .conv_chan_o    (conv_chan_o),
        .pending_o      (pending_o),
        .dma_req_o      (dma_req_o),
        .launch_o       (launch_o)
    );

    assign scan_o   = cfg_q.scan;
    assign sync_o   = cfg_q.sync;
    assign dma_en_o = cfg_q.dma;

endmodule

// File: rtl/prio_group_seq_chk.sv
// Protocol checker for prio_group_seq, attached by bind below.
module prio_group_seq_chk #(
    parameter int NCH = 8,
    localparam int CW = $clog2(NCH)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          unit_en_i,
    input logic          conv_done_i,
    input logic          conv_start_o,
    input logic [CW-1:0] conv_chan_o,
    input logic          pending_o,
    input logic          dma_req_o,
    input logic          scan_o,
    input logic          sync_o,
    input logic          dma_en_o
);

    // A start pulse belongs to a pending request.
    p_start_in_request_r11: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start_o |-> pending_o);

    // Without a done, the channel of a pending request does not move.
    p_chan_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pending_o && !conv_done_i && unit_en_i) |=> $stable(conv_chan_o));

    // Disable clears all status on the next edge.
    p_disable_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !unit_en_i |=> (!pending_o && !conv_start_o && !dma_req_o));

    // Options are frozen while enabled.
    p_cfg_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        unit_en_i |=> $stable({scan_o, sync_o, dma_en_o}));

    // A DMA request needs the DMA option and a done while pending.
    p_dma_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req_o |-> (dma_en_o && $past(conv_done_i && pending_o)));

    // Continued scan conversions move strictly upward.
    p_scan_ascending_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_start_o && $past(pending_o) && scan_o) |-> (conv_chan_o > $past(conv_chan_o)));

endmodule

bind prio_group_seq prio_group_seq_chk #(.NCH(NCH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .unit_en_i    (unit_en_i),
    .conv_done_i  (conv_done_i),
    .conv_start_o (conv_start_o),
    .conv_chan_o  (conv_chan_o),
    .pending_o    (pending_o),
    .dma_req_o    (dma_req_o),
    .scan_o       (scan_o),
    .sync_o       (sync_o),
    .dma_en_o     (dma_en_o)
);

// File: tb/prio_group_seq_tb_top.sv
`timescale 1ns/1ps
module prio_group_seq_tb_top;

    localparam int NCH = 8;
    localparam int CW  = $clog2(NCH);

    logic clk = 1'b0;
    logic rst_n, unit_en_i, cfg_we_i, cfg_scan_i, cfg_sync_i, cfg_dma_i;
    logic mask_we_i, sw_start_i, master_start_i, conv_done_i;
    logic [NCH-1:0] mask_i;
    logic conv_start_o, pending_o, dma_req_o, launch_o, scan_o, sync_o, dma_en_o;
    logic [CW-1:0] conv_chan_o;

    always #2.5 clk = ~clk;

    prio_group_seq #(.NCH(NCH)) dut_i (.*);

    int checks = 0, failures = 0;
    string cur_tag = "R11";
    int q[$];
    int dma_cnt = 0;
    int rcnt = 0;
    bit auto_resp = 1'b1;
    bit spur_done = 1'b0;

    // Behavioural reference state
    int m_pend, m_start, m_chan, m_ptr, m_dma, m_scan, m_sync, m_dmaen, m_mask;

    function automatic int first_from(int mask, int base, bit wrap);
        for (int i = base; i < NCH; i++) if (mask[i]) return i;
        if (wrap) for (int i = 0; i < NCH; i++) if (mask[i]) return i;
        return -1;
    endfunction

    // Reference model, updated from the inputs present at each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_pend = 0; m_start = 0; m_chan = 0; m_ptr = 0; m_dma = 0;
            m_scan = 0; m_sync = 0; m_dmaen = 0; m_mask = 0;
        end else begin
            if (!unit_en_i) begin
                m_pend = 0; m_start = 0; m_chan = 0; m_ptr = 0; m_dma = 0;
            end else begin
                int ns, nd, c;
                ns = 0; nd = 0;
                if (!m_pend && (sw_start_i || (m_sync && master_start_i))) begin
                    c = first_from(m_mask, m_scan ? 0 : m_ptr, 1'b1);
                    if (c >= 0) begin m_pend = 1; ns = 1; m_chan = c; end
                end else if (m_pend && !m_start && conv_done_i) begin
                    nd = m_dmaen;
                    if (m_scan) begin
                        c = first_from(m_mask, m_chan + 1, 1'b0);
                        if (c >= 0) begin m_chan = c; ns = 1; end
                        else m_pend = 0;
                    end else begin
                        m_pend = 0;
                        m_ptr = (m_chan + 1) % NCH;
                    end
                end
                if (mask_we_i && !m_scan) m_ptr = 0;
                m_start = ns; m_dma = nd;
            end
            if (cfg_we_i && !unit_en_i) begin
                m_scan = cfg_scan_i; m_sync = cfg_sync_i; m_dmaen = cfg_dma_i;
            end
            if (mask_we_i) m_mask = int'(mask_i);
        end
    end

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // One cycle: compare with model at the falling edge, then run responder
    task automatic tick();
        @(negedge clk);
        begin
            int got, exp;
            got = {conv_start_o, pending_o, dma_req_o, launch_o, scan_o, sync_o, dma_en_o};
            exp = {m_start[0], m_pend[0], m_dma[0],
                   unit_en_i && !m_pend[0] && sw_start_i && rst_n,
                   m_scan[0], m_sync[0], m_dmaen[0]};
            chk(got == exp, cur_tag, "model flags", got, exp);
            if (m_start != 0) chk(int'(conv_chan_o) == m_chan, cur_tag, "model chan", conv_chan_o, m_chan);
        end
        if (conv_start_o) q.push_back(int'(conv_chan_o));
        if (dma_req_o) dma_cnt++;
        if (auto_resp) begin
            if (conv_start_o) rcnt = 2;
            else if (rcnt > 0) rcnt--;
        end
        conv_done_i = (auto_resp && rcnt == 1) || spur_done;
    endtask

    task automatic set_cfg(input bit s, input bit y, input bit d);
        cfg_scan_i = s; cfg_sync_i = y; cfg_dma_i = d; cfg_we_i = 1'b1;
        tick();
        cfg_we_i = 1'b0;
    endtask

    task automatic write_mask(input logic [NCH-1:0] m);
        mask_i = m; mask_we_i = 1'b1;
        tick();
        mask_we_i = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 60 && pending_o; i++) tick();
        tick();
    endtask

    task automatic start_sw();
        sw_start_i = 1'b1;
        tick();
        sw_start_i = 1'b0;
        wait_idle();
    endtask

    initial begin
        #(5.0 * 200000);
        failures++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n = 0; unit_en_i = 0; cfg_we_i = 0; cfg_scan_i = 0; cfg_sync_i = 0;
        cfg_dma_i = 0; mask_we_i = 0; mask_i = '0; sw_start_i = 0;
        master_start_i = 0; conv_done_i = 0;
        repeat (3) tick();
        // R11: reset state
        chk(!pending_o && !conv_start_o && !dma_req_o, "R11", "reset flags", pending_o, 0);
        rst_n = 1;
        tick();

        // R1 / R2: single mode stepping and wrap over mask bits 0,2,5
        cur_tag = "R1";
        write_mask(8'h25);
        unit_en_i = 1; tick();
        q.delete();
        sw_start_i = 1; tick(); sw_start_i = 0;
        chk(pending_o && conv_start_o, "R11", "pending after start", pending_o, 1);
        wait_idle();
        start_sw(); start_sw();
        chk(q.size() == 3 && q[0] == 0 && q[1] == 2 && q[2] == 5, "R1", "single order 0,2,5",
            q.size() == 3 ? q[2] : -1, 5);
        cur_tag = "R2";
        start_sw();
        chk(q.size() == 4 && q[3] == 0, "R2", "wrap to lowest", q[q.size()-1], 0);
        chk(!pending_o, "R11", "pending cleared after single done", pending_o, 0);
        start_sw();   // converts 2, pointer now 3

        // R4: new mask {2,3,5} restarts at 2, not at 3
        cur_tag = "R4";
        write_mask(8'h2C);
        q.delete();
        start_sw();
        chk(q.size() == 1 && q[0] == 2, "R4", "mask write resets pointer", q.size() ? q[0] : -1, 2);

        // R12: stray done while idle moves nothing; next start converts 3
        cur_tag = "R12";
        spur_done = 1; tick(); spur_done = 0; tick();
        chk(!pending_o && q.size() == 1, "R12", "stray done ignored", q.size(), 1);
        start_sw();
        chk(q.size() == 2 && q[1] == 3, "R12", "pointer unchanged by stray done", q[q.size()-1], 3);

        // R10: empty mask
        cur_tag = "R10";
        write_mask(8'h00);
        q.delete();
        sw_start_i = 1; #1;
        chk(launch_o == 1, "R6", "launch on idle software start", launch_o, 1);
        tick(); sw_start_i = 0; tick();
        chk(!pending_o && q.size() == 0, "R10", "empty mask issues nothing", q.size(), 0);

        // R8: abort mid-conversion and pointer reset
        cur_tag = "R8";
        write_mask(8'h25);
        start_sw();                  // converts 0, pointer 1
        auto_resp = 0;
        sw_start_i = 1; tick(); sw_start_i = 0; tick();
        chk(pending_o == 1, "R8", "held pending", pending_o, 1);
        unit_en_i = 0; tick();
        chk(!pending_o && !conv_start_o, "R8", "disable clears pending", pending_o, 0);
        auto_resp = 1; rcnt = 0;
        unit_en_i = 1; tick();
        q.delete();
        start_sw();
        chk(q.size() == 1 && q[0] == 0, "R8", "pointer reset by disable", q.size() ? q[0] : -1, 0);

        // R7: options locked while enabled
        cur_tag = "R7";
        unit_en_i = 0; tick();
        set_cfg(1, 0, 0);
        unit_en_i = 1; tick();
        set_cfg(0, 1, 1);
        chk(scan_o && !sync_o && !dma_en_o, "R7", "write ignored while enabled",
            {scan_o, sync_o, dma_en_o}, 3'b100);

        // R3 / R5 / R9: scan over {1,4,7}, extra starts while pending
        cur_tag = "R3";
        write_mask(8'h92);
        q.delete(); dma_cnt = 0;
        start_sw();
        chk(q.size() == 3 && q[0] == 1 && q[1] == 4 && q[2] == 7, "R3", "scan order 1,4,7",
            q.size(), 3);
        chk(dma_cnt == 0, "R9", "no dma request when disabled option", dma_cnt, 0);
        cur_tag = "R5";
        q.delete();
        sw_start_i = 1; tick(); sw_start_i = 0; tick();
        sw_start_i = 1; tick(); sw_start_i = 0; tick(); tick();
        sw_start_i = 1; tick(); sw_start_i = 0;
        wait_idle();
        chk(q.size() == 3, "R5", "starts while pending ignored", q.size(), 3);

        // R6: master start without and with sync
        cur_tag = "R6";
        q.delete();
        master_start_i = 1; tick(); master_start_i = 0; tick();
        chk(!pending_o && q.size() == 0, "R6", "master start ignored without sync", q.size(), 0);
        unit_en_i = 0; tick();
        set_cfg(0, 1, 1);
        unit_en_i = 1; tick();
        write_mask(8'h92);
        dma_cnt = 0;
        master_start_i = 1; tick(); master_start_i = 0;
        chk(pending_o && conv_start_o && conv_chan_o == 1, "R6", "sync start launches",
            conv_chan_o, 1);
        wait_idle();
        chk(dma_cnt == 1, "R9", "one dma request per single conversion", dma_cnt, 1);

        // R9: scan with DMA gives one request per channel
        cur_tag = "R9";
        unit_en_i = 0; tick();
        set_cfg(1, 0, 1);
        unit_en_i = 1; tick();
        dma_cnt = 0;
        start_sw();
        chk(dma_cnt == 3, "R9", "dma request per scanned channel", dma_cnt, 3);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule